// File: doc/BRIEF.md
# Receive Buffer Resource Ring Manager

This block keeps track of the ring of receive-buffer resources that a host sets up in memory. It holds four 16-bit ring pointers: ring start, ring end, the read pointer the block owns, and the write pointer the host owns. It also holds the buffer address and the word count that remain in the buffer currently in use. When a fetch is requested, the block reads one four-field entry from a word stream at the address of the read pointer. It loads the 32-bit buffer address and the 32-bit word count from that entry. It then steps the read pointer forward, wrapping it at the end of the ring. If the read pointer has caught up with the host's write pointer, the block flags that resources are exhausted.

After each stored frame, the receive path pulses `frame_done` with the frame length. The block moves the buffer address forward by the frame plus four check bytes, and it reduces the word count by half of that byte total. When the remaining count drops below a programmable low-water mark, the block sets a last-frame status and starts a fetch on its own.

A single fetch state machine has four states. `ST_IDLE` waits for a request. `ST_FETCH` requests words and captures them. `ST_ADV` steps the read pointer. `ST_CHECK` compares the read pointer against the write pointer. The transitions are:
- idle-to-fetch, taken on any request.
- fetch-to-advance, taken on the fourth accepted word.
- advance-to-check, always taken.
- check-to-fetch, taken when a request is pending or arriving.
- check-to-idle, taken otherwise.

Top module: `rx_ring_mgr`

## Requirements
- R1: After reset the following values hold: buffer address, word count, read pointer, start, end and write pointer are all 0; `exhausted`, `last_pkt`, `fetch_busy` and `rd_req` are 0; `can_accept` is 1; the low-water mark is 0x02F8.
- R2: A fetch reads four 16-bit words in order: address low, address high, count low, count high. In narrow mode (`cfg_wide`=0), the word address is the read pointer plus 2 times the field index. `buf_ptr`={word1,word0} and `word_cnt`={word3,word2}.
- R3: In wide mode (`cfg_wide`=1), the fields sit at the read pointer plus 4 times the field index, and the read pointer advances by 16.
- R4: In narrow mode the read pointer advances by 8 per entry. If the advanced value equals the end register, the read pointer is reloaded from the start register.
- R5: After the advance, if the read pointer equals the write pointer, `exhausted` is set. While `exhausted` is 1, `can_accept` is 0.
- R6: `fetch_busy` rises on the clock after a request and falls when the fetch completes.
- R7: On `frame_done`, `buf_ptr` increases by `frame_len`+4 and `word_cnt` decreases by (`frame_len`+4)/2.
- R8: If the word count after a frame is below the low-water mark, `last_pkt` becomes 1 and a fetch starts on the next clock. Otherwise `last_pkt` becomes 0.
- R9: Requests that arrive while a fetch runs are held as one pending flag and served right after the current fetch.
- R10: A pulse on `exh_clr` clears `exhausted` and starts a fetch.
- R11: Writes use `wr_sel` as follows: 0 is start, 1 is end, 2 is read pointer, 3 is write pointer, 4 is low-water mark. The four pointers drop bit 0 of the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wide | input | 1 | 1 selects the 32-bit field stride |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for a write |
| wr_data | input | 16 | Write data |
| fetch_req | input | 1 | Request to read the next resource entry |
| exh_clr | input | 1 | Clear exhaustion and fetch again |
| rd_req | output | 1 | Word wanted at `rd_addr` |
| rd_addr | output | 16 | Byte address of the wanted word |
| rd_valid | input | 1 | `rd_data` holds the wanted word |
| rd_data | input | 16 | Descriptor word |
| frame_done | input | 1 | A frame has been stored |
| frame_len | input | 16 | Byte length of that frame, without check bytes |
| buf_ptr | output | 32 | Current buffer address |
| word_cnt | output | 32 | Words left in the buffer |
| rd_ptr | output | 16 | Resource read pointer |
| fetch_busy | output | 1 | Fetch in progress |
| exhausted | output | 1 | Resources exhausted |
| last_pkt | output | 1 | Last frame fit below the low-water mark |
| can_accept | output | 1 | Receiver may accept frames |

## Verification
Faults inside the block show up at the ports in specific ways:
- A field index that is off, or the wrong stride, shows up at once in the values of `buf_ptr` and `word_cnt` after the fetch. The bench uses a memory image in which every word is distinct, so such a fault cannot hide.
- A bad wrap, or a wrong step size, is visible on `rd_ptr` one clock after the last word.
- A wrong exhaustion compare is visible on `exhausted` and `can_accept` one clock later.
- A dropped pending flag leaves the read pointer one entry short once `fetch_busy` falls.
- An error in the frame accounting is visible on the next clock. It may also trip or miss the automatic refill, which then shows up as a change of `fetch_busy`.

// File: rtl/rrr_pkg.sv
package rrr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_ADV   = 2'd2,
        ST_CHECK = 2'd3
    } fetch_state_e;

    typedef enum logic [2:0] {
        SEL_START = 3'd0,
        SEL_END   = 3'd1,
        SEL_RDPTR = 3'd2,
        SEL_WRPTR = 3'd3,
        SEL_LOWM  = 3'd4
    } reg_sel_e;

    localparam int unsigned FIELDS = 4;

endpackage

// File: rtl/rrr_fetch_fsm.sv
module rrr_fetch_fsm
    import rrr_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_req,
    input  logic            rd_valid,
    input  logic [DW-1:0]   rd_data,
    output logic            rd_req,
    output logic [1:0]      word_idx,
    output logic            busy,
    output logic            pending,
    output logic            load_en,
    output logic [2*DW-1:0] load_ptr,
    output logic [2*DW-1:0] load_cnt,
    output logic            adv_en,
    output logic            check_en
);

    localparam int unsigned LAST_IDX = FIELDS - 1;

    fetch_state_e state_q, state_d;
    logic [DW-1:0] words_q [FIELDS-1];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d  = state_q;
        rd_req   = 1'b0;
        load_en  = 1'b0;
        adv_en   = 1'b0;
        check_en = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_req) state_d = ST_FETCH;
            end
            ST_FETCH: begin
                rd_req = 1'b1;
                if (rd_valid && (word_idx == 2'(LAST_IDX))) begin
                    load_en = 1'b1;
                    state_d = ST_ADV;
                end
            end
            ST_ADV: begin
                adv_en  = 1'b1;
                state_d = ST_CHECK;
            end
            ST_CHECK: begin
                check_en = 1'b1;
                state_d  = (pending || start_req) ? ST_FETCH : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign busy     = (state_q != ST_IDLE);
    assign load_ptr = {words_q[1], words_q[0]};
    assign load_cnt = {rd_data, words_q[2]};

    // field index and captured words
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_idx <= '0;
        end else if (state_q != ST_FETCH) begin
            word_idx <= '0;
        end else if (rd_valid) begin
            word_idx <= word_idx + 2'd1;
        end
    end

    generate
        for (genvar g = 0; g < FIELDS - 1; g++) begin : g_word
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    words_q[g] <= '0;
                end else if (state_q == ST_FETCH && rd_valid && word_idx == 2'(g)) begin
                    words_q[g] <= rd_data;
                end
            end
        end
    endgenerate

    // single pending flag for requests during a fetch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (state_q == ST_CHECK) begin
            pending <= 1'b0;
        end else if (start_req && state_q != ST_IDLE) begin
            pending <= 1'b1;
        end
    end

    p_busy_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && state_q == ST_IDLE) |=> busy);

    p_pending_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> (state_q != ST_IDLE));

    p_load_then_adv_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (adv_en && !rd_req));

endmodule

// File: rtl/rrr_ptr_unit.sv
module rrr_ptr_unit
    import rrr_pkg::*;
#(
    parameter int unsigned AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wide,
    input  logic          wr_en,
    input  reg_sel_e      wr_sel,
    input  logic [AW-1:0] wr_data,
    input  logic [1:0]    word_idx,
    input  logic          adv_en,
    input  logic          check_en,
    input  logic          exh_clr,
    output logic [AW-1:0] rd_addr,
    output logic [AW-1:0] rrp,
    output logic          exhausted
);

    localparam logic [AW-1:0] STEP_NARROW = AW'(2 * FIELDS);
    localparam logic [AW-1:0] STEP_WIDE   = AW'(4 * FIELDS);
    localparam logic [AW-1:0] EVEN_MASK   = ~AW'(1);

    logic [AW-1:0] start_q, end_q, wp_q;
    logic [AW-1:0] step, nxt;

    assign step    = wide ? STEP_WIDE : STEP_NARROW;
    assign nxt     = rrp + step;
    assign rd_addr = rrp + (AW'(word_idx) << (wide ? 2 : 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= '0;
            end_q   <= '0;
            wp_q    <= '0;
        end else if (wr_en) begin
            unique case (wr_sel)
                SEL_START: start_q <= wr_data & EVEN_MASK;
                SEL_END:   end_q   <= wr_data & EVEN_MASK;
                SEL_WRPTR: wp_q    <= wr_data & EVEN_MASK;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rrp <= '0;
        end else if (adv_en) begin
            rrp <= (nxt == end_q) ? start_q : nxt;
        end else if (wr_en && wr_sel == SEL_RDPTR) begin
            rrp <= wr_data & EVEN_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exhausted <= 1'b0;
        end else if (check_en && rrp == wp_q) begin
            exhausted <= 1'b1;
        end else if (exh_clr) begin
            exhausted <= 1'b0;
        end
    end

    p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_en && !wr_en && start_q != end_q) |=> (rrp != end_q));

    p_exh_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(exhausted) |-> $past(rrp == wp_q));

    p_even_ptr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rrp[0] == 1'b0) && (start_q[0] == 1'b0));

endmodule

// File: rtl/rrr_buf_acct.sv
module rrr_buf_acct
    import rrr_pkg::*;
#(
    parameter int unsigned CW        = 32,
    parameter int unsigned LW        = 16,
    parameter int unsigned MW        = 16,
    parameter int unsigned FCS_BYTES = 4,
    parameter logic [MW-1:0] LOWM_RESET = 16'h02F8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  reg_sel_e      wr_sel,
    input  logic [MW-1:0] wr_data,
    input  logic          load_en,
    input  logic [CW-1:0] load_ptr,
    input  logic [CW-1:0] load_cnt,
    input  logic          frame_done,
    input  logic [LW-1:0] frame_len,
    output logic [CW-1:0] buf_ptr,
    output logic [CW-1:0] word_cnt,
    output logic          last_pkt,
    output logic          refill_req
);

    logic [MW-1:0] lowm_q;
    logic [CW-1:0] total, cnt_nxt;
    logic          upd, low_space;

    assign total     = CW'(frame_len) + CW'(FCS_BYTES);
    assign cnt_nxt   = word_cnt - (total >> 1);
    assign upd       = frame_done && !load_en;
    assign low_space = cnt_nxt < CW'(lowm_q);
    assign refill_req = upd && low_space;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          lowm_q <= LOWM_RESET;
        else if (wr_en && wr_sel == SEL_LOWM) lowm_q <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_ptr  <= '0;
            word_cnt <= '0;
            last_pkt <= 1'b0;
        end else if (load_en) begin
            buf_ptr  <= load_ptr;
            word_cnt <= load_cnt;
        end else if (upd) begin
            buf_ptr  <= buf_ptr + total;
            word_cnt <= cnt_nxt;
            last_pkt <= low_space;
        end
    end

    p_frame_adv_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !load_en) |=>
            (buf_ptr == $past(buf_ptr) + CW'($past(frame_len)) + CW'(FCS_BYTES)));

    p_last_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(last_pkt) |-> $past(frame_done));

endmodule

// File: rtl/rx_ring_mgr.sv
module rx_ring_mgr
    import rrr_pkg::*;
#(
    parameter int unsigned AW = 16,
    parameter int unsigned DW = 16,
    parameter int unsigned LW = 16,
    parameter logic [15:0] LOWM_RESET = 16'h02F8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_wide,
    input  logic            wr_en,
    input  logic [2:0]      wr_sel,
    input  logic [15:0]     wr_data,
    input  logic            fetch_req,
    input  logic            exh_clr,
    output logic            rd_req,
    output logic [AW-1:0]   rd_addr,
    input  logic            rd_valid,
    input  logic [DW-1:0]   rd_data,
    input  logic            frame_done,
    input  logic [LW-1:0]   frame_len,
    output logic [2*DW-1:0] buf_ptr,
    output logic [2*DW-1:0] word_cnt,
    output logic [AW-1:0]   rd_ptr,
    output logic            fetch_busy,
    output logic            exhausted,
    output logic            last_pkt,
    output logic            can_accept
);

    localparam int unsigned CW = 2 * DW;

    reg_sel_e        sel;
    logic            refill_req, start_req, pending;
    logic            load_en, adv_en, check_en;
    logic [1:0]      word_idx;
    logic [CW-1:0]   load_ptr, load_cnt;

    assign sel        = reg_sel_e'(wr_sel);
    assign start_req  = fetch_req | exh_clr | refill_req;
    assign can_accept = !exhausted;

    rrr_fetch_fsm #(.DW(DW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .rd_req    (rd_req),
        .word_idx  (word_idx),
        .busy      (fetch_busy),
        .pending   (pending),
        .load_en   (load_en),
        .load_ptr  (load_ptr),
        .load_cnt  (load_cnt),
        .adv_en    (adv_en),
        .check_en  (check_en)
    );

    rrr_ptr_unit #(.AW(AW)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wide      (cfg_wide),
        .wr_en     (wr_en),
        .wr_sel    (sel),
        .wr_data   (AW'(wr_data)),
        .word_idx  (word_idx),
        .adv_en    (adv_en),
        .check_en  (check_en),
        .exh_clr   (exh_clr),
        .rd_addr   (rd_addr),
        .rrp       (rd_ptr),
        .exhausted (exhausted)
    );

    rrr_buf_acct #(
        .CW         (CW),
        .LW         (LW),
        .MW         (16),
        .LOWM_RESET (LOWM_RESET)
    ) u_acct (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (sel),
        .wr_data    (wr_data),
        .load_en    (load_en),
        .load_ptr   (load_ptr),
        .load_cnt   (load_cnt),
        .frame_done (frame_done),
        .frame_len  (frame_len),
        .buf_ptr    (buf_ptr),
        .word_cnt   (word_cnt),
        .last_pkt   (last_pkt),
        .refill_req (refill_req)
    );

    p_refill_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (refill_req && !fetch_busy) |=> fetch_busy);

    p_clr_fetch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        exh_clr |=> (fetch_busy && !$past(check_en) -> !exhausted));

    p_busy_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fetch_busy) |-> $past(check_en) && !$past(pending));

endmodule

// File: tb/rx_ring_mgr_tb_top.sv
module rx_ring_mgr_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wide = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic        fetch_req = 1'b0;
    logic        exh_clr = 1'b0;
    logic        rd_req;
    logic [15:0] rd_addr;
    logic        rd_valid = 1'b0;
    logic [15:0] rd_data = '0;
    logic        frame_done = 1'b0;
    logic [15:0] frame_len = '0;
    logic [31:0] buf_ptr, word_cnt;
    logic [15:0] rd_ptr;
    logic        fetch_busy, exhausted, last_pkt, can_accept;

    int checks = 0;
    int fails  = 0;
    logic [15:0] mem [128];

    always #10 clk = ~clk;

    rx_ring_mgr dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .fetch_req(fetch_req), .exh_clr(exh_clr),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .frame_done(frame_done), .frame_len(frame_len),
        .buf_ptr(buf_ptr), .word_cnt(word_cnt), .rd_ptr(rd_ptr),
        .fetch_busy(fetch_busy), .exhausted(exhausted),
        .last_pkt(last_pkt), .can_accept(can_accept)
    );

    // memory model: answers a word request within the same cycle
    always @(negedge clk) begin
        rd_valid <= rd_req;
        rd_data  <= mem[rd_addr[7:1]];
    end

    function automatic logic [15:0] memw(input logic [15:0] a);
        return mem[a[7:1]];
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic fetch_pulse();
        @(negedge clk);
        fetch_req = 1'b1;
        @(negedge clk);
        fetch_req = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 100 && fetch_busy; i++) @(negedge clk);
    endtask

    task automatic frame(input logic [15:0] len);
        @(negedge clk);
        frame_done = 1'b1; frame_len = len;
        @(negedge clk);
        frame_done = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1", "buf_ptr", buf_ptr, 32'h0);
        check("R1", "word_cnt", word_cnt, 32'h0);
        check("R1", "rd_ptr", {16'h0, rd_ptr}, 32'h0);
        check("R1", "flags", {28'h0, exhausted, last_pkt, fetch_busy, rd_req}, 32'h0);
        check("R1", "can_accept", {31'h0, can_accept}, 32'h1);
    endtask

    task automatic t_ptr_mask();
        wr(3'd3, 16'h00F0);
        wr(3'd1, 16'h00E0);
        wr(3'd2, 16'h0035);
        check("R11", "rd_ptr bit0 dropped", {16'h0, rd_ptr}, 32'h34);
    endtask

    task automatic t_fetch_narrow();
        logic [15:0] a = 16'h0010;
        wr(3'd2, a);
        fetch_pulse();
        check("R6", "busy after request", {31'h0, fetch_busy}, 32'h1);
        wait_idle();
        check("R6", "busy cleared", {31'h0, fetch_busy}, 32'h0);
        check("R2", "buf_ptr narrow", buf_ptr, {memw(a + 2), memw(a)});
        check("R2", "word_cnt narrow", word_cnt, {memw(a + 6), memw(a + 4)});
        check("R4", "advance by 8", {16'h0, rd_ptr}, 32'h18);
    endtask

    task automatic t_fetch_wide();
        logic [15:0] a = 16'h0020;
        cfg_wide = 1'b1;
        wr(3'd2, a);
        fetch_pulse();
        wait_idle();
        check("R3", "buf_ptr wide", buf_ptr, {memw(a + 4), memw(a)});
        check("R3", "word_cnt wide", word_cnt, {memw(a + 12), memw(a + 8)});
        check("R3", "advance by 16", {16'h0, rd_ptr}, 32'h30);
        cfg_wide = 1'b0;
    endtask

    task automatic t_pending();
        wr(3'd2, 16'h0070);
        @(negedge clk);
        fetch_req = 1'b1;
        @(negedge clk);
        @(negedge clk);
        fetch_req = 1'b0;
        wait_idle();
        check("R9", "two entries consumed", {16'h0, rd_ptr}, 32'h80);
        check("R9", "second entry loaded", buf_ptr, {memw(16'h7A), memw(16'h78)});
    endtask

    task automatic t_frames();
        mem[8'h60 >> 1] = 16'h0000;
        mem[8'h62 >> 1] = 16'h0001;
        mem[8'h64 >> 1] = 16'h0400;
        mem[8'h66 >> 1] = 16'h0000;
        wr(3'd2, 16'h0060);
        fetch_pulse();
        wait_idle();
        frame(16'd60);
        check("R7", "buf_ptr after 60", buf_ptr, 32'h0001_0040);
        check("R7", "word_cnt after 60", word_cnt, 32'h0000_03E0);
        check("R8", "no last above mark", {30'h0, last_pkt, fetch_busy}, 32'h0);
        frame(16'h0100);
        check("R7", "word_cnt after 256", word_cnt, 32'h0000_035E);
        frame(16'd204);
        check("R8", "word_cnt below mark", word_cnt, 32'h0000_02F6);
        check("R8", "last_pkt set", {31'h0, last_pkt}, 32'h1);
        check("R8", "refill started", {31'h0, fetch_busy}, 32'h1);
        wait_idle();
        check("R8", "refill loaded count", word_cnt, {memw(16'h6E), memw(16'h6C)});
        check("R8", "refill advanced", {16'h0, rd_ptr}, 32'h70);
    endtask

    task automatic t_wrap_exhaust();
        wr(3'd0, 16'h0041);
        wr(3'd1, 16'h0050);
        wr(3'd3, 16'h0040);
        wr(3'd2, 16'h0048);
        fetch_pulse();
        wait_idle();
        check("R4", "wrap to start", {16'h0, rd_ptr}, 32'h40);
        check("R5", "exhausted", {31'h0, exhausted}, 32'h1);
        check("R5", "can_accept low", {31'h0, can_accept}, 32'h0);
    endtask

    task automatic t_exh_clear();
        @(negedge clk);
        exh_clr = 1'b1;
        @(negedge clk);
        exh_clr = 1'b0;
        check("R10", "cleared", {31'h0, exhausted}, 32'h0);
        check("R10", "fetch started", {31'h0, fetch_busy}, 32'h1);
        wait_idle();
        check("R10", "entry at 0x40 loaded", buf_ptr, {memw(16'h42), memw(16'h40)});
        check("R10", "rd_ptr advanced", {16'h0, rd_ptr}, 32'h48);
        check("R10", "can_accept again", {31'h0, can_accept}, 32'h1);
    endtask

    initial begin
        for (int i = 0; i < 128; i++) mem[i] = 16'hA000 + 16'(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ptr_mask();
        t_fetch_narrow();
        t_fetch_wide();
        t_pending();
        t_frames();
        t_wrap_exhaust();
        t_exh_clear();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule